// File: doc/BRIEF.md
# SPI Channel Register and Interrupt Bank

This block is the software-visible register bank of one serial-peripheral channel. A host reaches it over a simple request/write-enable bus. It holds the configuration word, the clock divider, the command word, the interrupt enables and a pair of FIFO thresholds. It also contains two word FIFOs. The transmit FIFO is filled by host writes and drained by the shift engine. The receive FIFO is filled by the engine and drained by host reads. The serial shifting itself lives in the engine, outside this block.

A sticky status word records the progress of a transfer, threshold crossings, transmit underflow and receive overflow. The host clears these bits by writing ones. One interrupt line combines the status causes that are enabled. The enable bits sit one position lower than the status bits they gate. Each channel instance answers at its own window of `CHAN_STRIDE` bytes, placed at `CHAN_ID` times the stride. A system-control word shared by all channels sits at byte address 0x100. It holds the soft reset, the clock-gate request and the power-management enable.

Top module: `spi_chan_regs`

## Requirements
- R1: After rst_ni is released, the configuration, divider, command and enable words read 0. The count word reads 0, the threshold word reads 0x01, irq_o is low and pending_o is low.
- R2: This channel's words sit at byte address CHAN_ID*CHAN_STRIDE plus the offset: configuration 0x00, divider 0x04, command 0x08, status 0x0C, enable 0x10, threshold 0x14, count 0x18, transmit data 0x1C, receive data 0x20. Writes inside another channel's window leave this channel unchanged, and reads there return 0.
- R3: A write to transmit data pushes a word into an 8-deep transmit FIFO. The engine sees the FIFO head on tx_data_o and advances it with tx_pop_i, in write order. A write to a full FIFO is dropped. The count word reports transmit occupancy in bits [7:4], and a read of transmit data returns 0.
- R4: rx_push_i stores rx_data_i in an 8-deep receive FIFO. Each read of receive data returns the oldest word and removes it. A read of an empty FIFO returns 0. The count word reports receive occupancy in bits [3:0].
- R5: A command write while no transfer is pending stores the word. It raises start_o for exactly one cycle, and pending_o (status bit 0) rises with it. A command write while pending is ignored: the stored word is unchanged and start_o stays low.
- R6: eng_done_i while pending clears status bit 0 and sets status bit 1. eng_done_i while not pending sets nothing. Bit 1 is cleared by writing 1, and writing 1 to bit 0 has no effect.
- R7: The threshold word holds a transmit level in bits [7:4] and a receive level in bits [3:0]. Status bit 2 is set while transmit occupancy is at or below its level. Status bit 3 is set while receive occupancy is at or above its level. A write of 1 clears either bit only once its condition no longer holds.
- R8: tx_pop_i on an empty transmit FIFO sets status bit 4. rx_push_i on a full receive FIFO drops the word and sets status bit 5. Both bits stay set until a 1 is written to them.
- R9: irq_o is high exactly when some status bit k (k = 1..5) is set together with enable bit k-1.
- R10: The system word at 0x100 reads back as written. Its bit CHAN_ID, seen on chan_srst_o, holds this channel in soft reset while set: both FIFOs empty, status 0, pending low, transmit writes dropped, configuration kept. Its bit 1 drives clk_dis_o and its bit 8 drives pm_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid in the request cycle |
| cfg_o | output | DATA_W | Configuration word to the engine |
| div_o | output | DIV_W | Clock divider to the engine |
| cmd_o | output | DATA_W | Accepted command word |
| start_o | output | 1 | One-cycle start pulse |
| pending_o | output | 1 | Transfer pending |
| tx_pop_i | input | 1 | Engine takes the transmit head |
| tx_data_o | output | DATA_W | Transmit FIFO head |
| rx_push_i | input | 1 | Engine delivers a receive word |
| rx_data_i | input | DATA_W | Receive word |
| eng_done_i | input | 1 | Engine finished the transfer |
| chan_srst_o | output | 1 | Channel soft reset active |
| clk_dis_o | output | 1 | Clock disable request |
| pm_en_o | output | 1 | Power management enable |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the bank with CHAN_ID = 2 and all other parameters at their defaults. This places the window at 0x80, away from address 0, so writes to channels 0 and 3 can be shown to miss. It also puts the soft-reset bit at position 2, clear of the clock-disable bit 1, so each control can be observed alone. The default depth of 8 lets both FIFOs be filled to the full mark and driven past it, and lets a single count word carry both occupancies in its two nibbles.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  localparam int OFS_CFG  = 'h00;
  localparam int OFS_DIV  = 'h04;
  localparam int OFS_CMD  = 'h08;
  localparam int OFS_STAT = 'h0C;
  localparam int OFS_IEN  = 'h10;
  localparam int OFS_THR  = 'h14;
  localparam int OFS_CNT  = 'h18;
  localparam int OFS_TXD  = 'h1C;
  localparam int OFS_RXD  = 'h20;
  localparam int SYS_ADDR = 'h100;
  localparam int SYS_CLKDIS = 1;
  localparam int SYS_PMEN   = 8;
  localparam int ST_W  = 6;
  localparam int IEN_W = 5;

  // packed MSB first: bit 0 = pend, bit 5 = rxof
  typedef struct packed {
    logic rxof;
    logic txuf;
    logic rxth;
    logic txth;
    logic done;
    logic pend;
  } stat_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, empty, do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push_i & ~full & ~clr_i;
  assign do_pop  = pop_i & ~empty & ~clr_i;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem[rp_q];
  assign cnt_o   = cnt_q;

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CNT_W'(DEPTH));
  assert_full_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && cnt_o == CNT_W'(DEPTH) && !pop_i && !clr_i) |=> cnt_o == CNT_W'(DEPTH));
  assert_empty_pop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && cnt_o == '0 && !push_i && !clr_i) |=> cnt_o == '0);
endmodule

// File: rtl/spi_stat_ctrl.sv
module spi_stat_ctrl
  import spi_regs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             cmd_wr_i,
  input  logic             done_i,
  input  logic             txuf_i,
  input  logic             rxof_i,
  input  logic             txth_i,
  input  logic             rxth_i,
  input  logic [ST_W-1:0]  w1c_i,
  input  logic [IEN_W-1:0] ien_i,
  output logic             cmd_acc_o,
  output logic             start_o,
  output stat_t            st_o,
  output logic             irq_o
);
  stat_t st_q;
  logic  start_q;

  assign cmd_acc_o = cmd_wr_i & ~st_q.pend & ~flush_i;

  // level causes: set dominates the write-one clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= cmd_acc_o;
      if (flush_i) begin
        st_q <= '0;
      end else begin
        st_q.pend <= cmd_acc_o | (st_q.pend & ~done_i);
        st_q.done <= (st_q.done & ~w1c_i[1]) | (st_q.pend & done_i);
        st_q.txth <= (st_q.txth & ~w1c_i[2]) | txth_i;
        st_q.rxth <= (st_q.rxth & ~w1c_i[3]) | rxth_i;
        st_q.txuf <= (st_q.txuf & ~w1c_i[4]) | txuf_i;
        st_q.rxof <= (st_q.rxof & ~w1c_i[5]) | rxof_i;
      end
    end
  end

  assign st_o    = st_q;
  assign start_o = start_q;
  assign irq_o   = |({st_q.rxof, st_q.txuf, st_q.rxth, st_q.txth, st_q.done} & ien_i);

  assert_start_pend_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> st_q.pend);
  assert_busy_ignore_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && st_q.pend) |=> !start_o);
  assert_pend_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(st_q.pend) |-> $past(done_i || flush_i));
  assert_ovf_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q.rxof && !w1c_i[5] && !flush_i) |=> st_q.rxof);
endmodule

// File: rtl/spi_chan_regs.sv
module spi_chan_regs
  import spi_regs_pkg::*;
#(
  parameter int CHAN_ID     = 0,
  parameter int DATA_W      = 32,
  parameter int DIV_W       = 16,
  parameter int FIFO_DEPTH  = 8,
  parameter int CHAN_STRIDE = 64,
  parameter int ADDR_W      = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [DATA_W-1:0] cmd_o,
  output logic              start_o,
  output logic              pending_o,
  input  logic              tx_pop_i,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              eng_done_i,
  output logic              chan_srst_o,
  output logic              clk_dis_o,
  output logic              pm_en_o,
  output logic              irq_o
);
  localparam int OFS_W = $clog2(CHAN_STRIDE);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [DATA_W-1:0] cfg_q, cmd_q, sys_q, rx_head;
  logic [DIV_W-1:0]  div_q;
  logic [IEN_W-1:0]  ien_q;
  logic [CNT_W-1:0]  thr_tx_q, thr_rx_q, tx_cnt, rx_cnt;
  logic              chan_hit, sys_hit, wr, rd, srst;
  logic              tx_wr, rx_rd, cmd_wr, cmd_acc;
  logic [ST_W-1:0]   w1c;
  int                ofs;
  stat_t             st;

  assign chan_hit = (int'(addr_i[ADDR_W-1:OFS_W]) == CHAN_ID);
  assign sys_hit  = (int'(addr_i) == SYS_ADDR);
  assign ofs      = int'(addr_i[OFS_W-1:0]);
  assign wr       = req_i & we_i;
  assign rd       = req_i & ~we_i;
  assign srst     = sys_q[CHAN_ID];

  assign tx_wr  = wr & chan_hit & (ofs == OFS_TXD);
  assign rx_rd  = rd & chan_hit & (ofs == OFS_RXD);
  assign cmd_wr = wr & chan_hit & (ofs == OFS_CMD);
  assign w1c    = (wr && chan_hit && ofs == OFS_STAT) ?
                  (wdata_i[ST_W-1:0] & ~ST_W'(1)) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      div_q    <= '0;
      cmd_q    <= '0;
      ien_q    <= '0;
      thr_tx_q <= '0;
      thr_rx_q <= CNT_W'(1);
      sys_q    <= '0;
    end else begin
      if (wr && chan_hit) begin
        case (ofs)
          OFS_CFG: cfg_q <= wdata_i;
          OFS_DIV: div_q <= wdata_i[DIV_W-1:0];
          OFS_IEN: ien_q <= wdata_i[IEN_W-1:0];
          OFS_THR: begin
            thr_rx_q <= wdata_i[CNT_W-1:0];
            thr_tx_q <= wdata_i[2*CNT_W-1:CNT_W];
          end
          default: ;
        endcase
      end
      if (wr && sys_hit) sys_q <= wdata_i;
      if (cmd_acc) cmd_q <= wdata_i;
    end
  end

  spi_word_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .clr_i(srst), .push_i(tx_wr), .wdata_i(wdata_i),
    .pop_i(tx_pop_i), .rdata_o(tx_data_o), .cnt_o(tx_cnt)
  );

  spi_word_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .clr_i(srst), .push_i(rx_push_i), .wdata_i(rx_data_i),
    .pop_i(rx_rd), .rdata_o(rx_head), .cnt_o(rx_cnt)
  );

  spi_stat_ctrl u_stat (
    .clk_i, .rst_ni,
    .flush_i  (srst),
    .cmd_wr_i (cmd_wr),
    .done_i   (eng_done_i),
    .txuf_i   (tx_pop_i & (tx_cnt == '0)),
    .rxof_i   (rx_push_i & (rx_cnt == CNT_W'(FIFO_DEPTH))),
    .txth_i   (tx_cnt <= thr_tx_q),
    .rxth_i   (rx_cnt >= thr_rx_q),
    .w1c_i    (w1c),
    .ien_i    (ien_q),
    .cmd_acc_o(cmd_acc),
    .start_o  (start_o),
    .st_o     (st),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd && sys_hit) begin
      rdata_o = sys_q;
    end else if (rd && chan_hit) begin
      case (ofs)
        OFS_CFG:  rdata_o = cfg_q;
        OFS_DIV:  rdata_o = DATA_W'(div_q);
        OFS_CMD:  rdata_o = cmd_q;
        OFS_STAT: rdata_o = DATA_W'(st);
        OFS_IEN:  rdata_o = DATA_W'(ien_q);
        OFS_THR:  rdata_o = DATA_W'({thr_tx_q, thr_rx_q});
        OFS_CNT:  rdata_o = DATA_W'({tx_cnt, rx_cnt});
        OFS_RXD:  rdata_o = (rx_cnt == '0) ? '0 : rx_head;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign cfg_o       = cfg_q;
  assign div_o       = div_q;
  assign cmd_o       = cmd_q;
  assign pending_o   = st.pend;
  assign chan_srst_o = srst;
  assign clk_dis_o   = sys_q[SYS_CLKDIS];
  assign pm_en_o     = sys_q[SYS_PMEN];

  assert_srst_flush_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (tx_cnt == '0 && rx_cnt == '0 && !pending_o));
  assert_irq_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o);
endmodule

// File: tb/spi_chan_regs_bench.sv
module spi_chan_regs_bench;
  localparam int CH = 2;
  localparam logic [8:0] B = 9'(CH * 64);
  localparam int S_RD = 0, S_IRQ = 1, S_START = 2, S_PEND = 3, S_TXD = 4,
                 S_CLKDIS = 5, S_PMEN = 6, S_SRST = 7;

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0, tx_pop = 0, rx_push = 0, eng_done = 0, mon_req = 0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0, rx_data = '0;
  logic [31:0] rdata, cfg, cmd, tx_data;
  logic [15:0] div;
  logic start, pending, srst, clk_dis, pm_en, irq;
  int total = 0, bad = 0;
  item_t q[$];
  item_t cur;
  logic [31:0] got;

  always #2 clk = ~clk;

  spi_chan_regs #(.CHAN_ID(CH)) u_spi_chan_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cfg_o(cfg), .div_o(div), .cmd_o(cmd),
    .start_o(start), .pending_o(pending), .tx_pop_i(tx_pop), .tx_data_o(tx_data),
    .rx_push_i(rx_push), .rx_data_i(rx_data), .eng_done_i(eng_done),
    .chan_srst_o(srst), .clk_dis_o(clk_dis), .pm_en_o(pm_en), .irq_o(irq)
  );

  function automatic logic [31:0] pick(int sel);
    case (sel)
      S_RD:     return rdata;
      S_IRQ:    return 32'(irq);
      S_START:  return 32'(start);
      S_PEND:   return 32'(pending);
      S_TXD:    return tx_data;
      S_CLKDIS: return 32'(clk_dis);
      S_PMEN:   return 32'(pm_en);
      default:  return 32'(srst);
    endcase
  endfunction

  // monitor: compares one queued expectation per flagged cycle, mid low phase
  always @(negedge clk) begin
    #1;
    if (mon_req) begin
      if (q.size() == 0) begin
        bad++;
        $display("FAIL monitor: no expectation queued");
      end else begin
        cur = q.pop_front();
        got = pick(cur.sel);
        total++;
        if (got !== cur.exp) begin
          bad++;
          $display("FAIL %s sel=%0d got=%h exp=%h", cur.tag, cur.sel, got, cur.exp);
        end
      end
    end
  end

  task automatic drive(logic r, logic w, logic [8:0] a, logic [31:0] d,
                       logic tp, logic rp, logic [31:0] rd_d, logic dn, logic m);
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d;
    tx_pop = tp; rx_push = rp; rx_data = rd_d; eng_done = dn; mon_req = m;
  endtask

  task automatic idle();
    drive(0, 0, '0, '0, 0, 0, '0, 0, 0);
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    drive(1, 1, a, d, 0, 0, '0, 0, 0);
  endtask

  task automatic rd(logic [8:0] a, logic [31:0] e, string tag);
    item_t it;
    it.sel = S_RD; it.exp = e; it.tag = tag;
    q.push_back(it);
    drive(1, 0, a, '0, 0, 0, '0, 0, 1);
  endtask

  task automatic chk(int sel, logic [31:0] e, string tag);
    item_t it;
    it.sel = sel; it.exp = e; it.tag = tag;
    q.push_back(it);
    drive(0, 0, '0, '0, 0, 0, '0, 0, 1);
  endtask

  task automatic eng_pop();
    drive(0, 0, '0, '0, 1, 0, '0, 0, 0);
  endtask

  task automatic eng_push(logic [31:0] d);
    drive(0, 0, '0, '0, 0, 1, d, 0, 0);
  endtask

  task automatic eng_fin();
    drive(0, 0, '0, '0, 0, 0, '0, 1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(); idle();

    // R1 reset state
    rd(B + 9'h00, 32'h0, "R1 cfg");
    rd(B + 9'h04, 32'h0, "R1 div");
    rd(B + 9'h08, 32'h0, "R1 cmd");
    rd(B + 9'h10, 32'h0, "R1 ien");
    rd(B + 9'h18, 32'h0, "R1 cnt");
    rd(B + 9'h14, 32'h01, "R1 thr");
    chk(S_IRQ, 0, "R1 irq");
    chk(S_PEND, 0, "R1 pending");
    rd(B + 9'h0C, 32'h04, "R7 txth at reset");

    // R2 window decode
    wr(B + 9'h00, 32'hA5);
    rd(B + 9'h00, 32'hA5, "R2 cfg rb");
    wr(9'h000, 32'h33);
    wr(9'h0C0, 32'h77);
    rd(B + 9'h00, 32'hA5, "R2 other window");
    rd(9'h000, 32'h0, "R2 foreign read");
    wr(B + 9'h04, 32'h1234);
    rd(B + 9'h04, 32'h1234, "R2 div rb");

    // R3 transmit FIFO
    wr(B + 9'h1C, 32'h1111_1111);
    wr(B + 9'h1C, 32'h2222_2222);
    wr(B + 9'h1C, 32'h3333_3333);
    rd(B + 9'h18, 32'h30, "R3 cnt 3");
    chk(S_TXD, 32'h1111_1111, "R3 head");
    eng_pop();
    chk(S_TXD, 32'h2222_2222, "R3 head after pop");
    rd(B + 9'h18, 32'h20, "R3 cnt 2");
    for (int i = 0; i < 7; i++) wr(B + 9'h1C, 32'h4000_0000 + 32'(i));
    rd(B + 9'h18, 32'h80, "R3 full");
    chk(S_TXD, 32'h2222_2222, "R3 order 0"); eng_pop();
    chk(S_TXD, 32'h3333_3333, "R3 order 1"); eng_pop();
    for (int i = 0; i < 6; i++) begin
      chk(S_TXD, 32'h4000_0000 + 32'(i), "R3 order");
      eng_pop();
    end
    rd(B + 9'h18, 32'h0, "R3 drained, extra word dropped");
    rd(B + 9'h1C, 32'h0, "R3 txdata read");

    // R8 underflow
    eng_pop();
    rd(B + 9'h0C, 32'h14, "R8 txuf set");
    wr(B + 9'h0C, 32'h10);
    rd(B + 9'h0C, 32'h04, "R8 txuf cleared");

    // R4 receive FIFO
    eng_push(32'hA1); eng_push(32'hA2); eng_push(32'hA3);
    rd(B + 9'h18, 32'h03, "R4 cnt 3");
    rd(B + 9'h20, 32'hA1, "R4 first");
    rd(B + 9'h20, 32'hA2, "R4 second");
    rd(B + 9'h18, 32'h01, "R4 cnt 1");
    rd(B + 9'h20, 32'hA3, "R4 third");
    rd(B + 9'h20, 32'h0, "R4 empty read");
    rd(B + 9'h18, 32'h0, "R4 cnt 0");

    // R7 thresholds
    wr(B + 9'h14, 32'h22);
    rd(B + 9'h14, 32'h22, "R7 thr rb");
    wr(B + 9'h0C, 32'h0C);
    rd(B + 9'h0C, 32'h04, "R7 txth held, rxth cleared");
    eng_push(32'hB1); eng_push(32'hB2); idle();
    rd(B + 9'h0C, 32'h0C, "R7 rxth at level");
    wr(B + 9'h1C, 32'hC1); wr(B + 9'h1C, 32'hC2); wr(B + 9'h1C, 32'hC3);
    wr(B + 9'h0C, 32'h04);
    rd(B + 9'h0C, 32'h08, "R7 txth clears above level");
    rd(B + 9'h20, 32'hB1, "R4 drain 1");
    rd(B + 9'h20, 32'hB2, "R4 drain 2");
    eng_pop(); eng_pop(); eng_pop();
    wr(B + 9'h0C, 32'h3E);
    rd(B + 9'h0C, 32'h04, "R7 txth re-asserts");

    // R5 / R6 command and done
    wr(B + 9'h08, 32'h00FF_0013);
    chk(S_START, 1, "R5 start pulse");
    chk(S_START, 0, "R5 start one cycle");
    chk(S_PEND, 1, "R5 pending");
    rd(B + 9'h0C, 32'h05, "R5 status pend");
    wr(B + 9'h08, 32'h0000_DEAD);
    chk(S_START, 0, "R5 busy write no start");
    rd(B + 9'h08, 32'h00FF_0013, "R5 busy write ignored");
    wr(B + 9'h0C, 32'h01);
    rd(B + 9'h0C, 32'h05, "R6 pend not w1c");
    eng_fin();
    chk(S_PEND, 0, "R6 pending cleared");
    rd(B + 9'h0C, 32'h06, "R6 done set");
    wr(B + 9'h0C, 32'h02);
    rd(B + 9'h0C, 32'h04, "R6 done cleared");
    eng_fin(); idle();
    rd(B + 9'h0C, 32'h04, "R6 stray done ignored");

    // R9 interrupt mapping
    wr(B + 9'h10, 32'h01);
    chk(S_IRQ, 0, "R9 done cause off");
    wr(B + 9'h10, 32'h02);
    chk(S_IRQ, 1, "R9 txth cause");
    wr(B + 9'h10, 32'h04);
    chk(S_IRQ, 0, "R9 rxth cause off");
    for (int i = 0; i < 9; i++) eng_push(32'hD000_0000 + 32'(i));
    rd(B + 9'h18, 32'h08, "R8 rx full, extra dropped");
    wr(B + 9'h10, 32'h10);
    chk(S_IRQ, 1, "R9 rxof cause");
    wr(B + 9'h0C, 32'h20);
    chk(S_IRQ, 0, "R8 rxof cleared");
    for (int i = 0; i < 8; i++) rd(B + 9'h20, 32'hD000_0000 + 32'(i), "R4 full order");
    rd(B + 9'h20, 32'h0, "R4 empty after full");

    // R10 system control
    rd(9'h100, 32'h0, "R10 sys reset value");
    wr(B + 9'h1C, 32'hE1); wr(B + 9'h1C, 32'hE2);
    eng_push(32'hF1);
    wr(B + 9'h08, 32'h1);
    chk(S_PEND, 1, "R10 pending before srst");
    wr(9'h100, 32'h106);
    chk(S_SRST, 1, "R10 srst");
    chk(S_CLKDIS, 1, "R10 clk_dis");
    chk(S_PMEN, 1, "R10 pm_en");
    rd(B + 9'h18, 32'h0, "R10 fifos flushed");
    chk(S_PEND, 0, "R10 pending flushed");
    rd(B + 9'h0C, 32'h0, "R10 status flushed");
    wr(B + 9'h1C, 32'hBEEF);
    rd(B + 9'h18, 32'h0, "R10 tx write dropped");
    rd(9'h100, 32'h106, "R10 sys rb");
    wr(9'h100, 32'h0);
    idle(); idle();
    rd(B + 9'h0C, 32'h04, "R10 status after release");
    rd(B + 9'h00, 32'hA5, "R10 cfg kept");
    chk(S_SRST, 0, "R10 srst released");

    idle(); idle();
    if (q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard: %0d expectations left", q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule